// File: doc/BRIEF.md
# Head Settle Delay Timer

This block times the pause a drive head needs after an implied seek before any read or write may begin. The pause is a number of time units. The number comes from a 4-bit settle factor. The length of one unit depends on the data rate chosen when the timer starts. At the slowest rate a unit is 8 ms, so the longest pause is 120 ms. At 300 kbps a unit is 6.666 ms, with a top of 100 ms. At 500 kbps a unit is 4 ms, with a top of 60 ms. At the fastest rate a unit is 2 ms, with a top of 30 ms.

Time is measured by counting pulses of an external time base, `tick`. The parameter `TICKS_PER_MS` states how many ticks make up one millisecond. From it the block works out a whole number of ticks per unit for each rate, rounded to the nearest tick. With the default of 3 ticks per millisecond, even the 6.666 ms unit is an exact 20 ticks. The settle factor is held in a register that is loaded through a write strobe and resets to 8. A `start` pulse captures that factor and the rate select. `busy` stays high while the count runs. `settled` pulses for one cycle when the count is done.

Top module: `settle_timer`

## Requirements
- R1: After reset, `busy` and `settled` are 0 and the stored settle factor is 8, so a start with no prior write times 8 units.
- R2: A cycle with `factor_wr` high loads `factor_in` into the stored settle factor. Every later start uses the value loaded last.
- R3: The delay is factor × unit ticks. The unit is set by `rate_sel`: 0 = 8 ms (24 ticks), 1 = 6.666 ms (20 ticks), 2 = 4 ms (12 ticks), 3 = 2 ms (6 ticks). The tick counts are for the default of 3 ticks per ms.
- R4: `settled` is high for exactly one cycle. That cycle follows the clock edge that samples the final required tick, and `busy` falls in the same cycle.
- R5: With a nonzero factor, `busy` is high from the cycle after `start` until completion, and `settled` stays low until then.
- R6: A stored factor of 0 makes `settled` pulse in the cycle after `start`, and `busy` stays low.
- R7: A `start` while `busy` is high discards the running count. It restarts with the current stored factor and the current `rate_sel`.
- R8: While idle, ticks have no effect: no `settled` pulse and no `busy`.
- R9: Changes to `rate_sel` or to the stored factor during a running count do not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse, one cycle wide, `TICKS_PER_MS` per millisecond |
| start | input | 1 | Begins (or restarts) a settle wait |
| rate_sel | input | 2 | Data rate: 0=250, 1=300, 2=500, 3=1000 kbps |
| factor_wr | input | 1 | Load strobe for the stored settle factor |
| factor_in | input | 4 | New settle factor value |
| busy | output | 1 | Settle wait in progress |
| settled | output | 1 | One-cycle pulse at the end of the wait |

## Verification
Embedded properties watch several things on every cycle. `settled` never lasts beyond one cycle and never coincides with `busy`. A start with a nonzero factor always raises `busy`, and a zero factor always gives an immediate pulse. The tick counter within a unit never reaches the unit length. The exact delay length can only be shown by the bench's scenarios. So can the per-rate unit sizes, the reset default of 8, restart behaviour, and immunity to idle ticks and to input changes mid-count. The scenarios count the ticks they drive and compare against factor × unit, with both dense and sparse tick patterns.

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int TICKS_PER_MS = 3,
  parameter int FACTOR_W     = 4,
  parameter int FACTOR_RST   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic [1:0]          rate_sel,
  input  logic                factor_wr,
  input  logic [FACTOR_W-1:0] factor_in,
  output logic                busy,
  output logic                settled
);

  localparam int UT_R0 = (8000 * TICKS_PER_MS + 500) / 1000;
  localparam int UT_R1 = (6667 * TICKS_PER_MS + 500) / 1000;
  localparam int UT_R2 = (4000 * TICKS_PER_MS + 500) / 1000;
  localparam int UT_R3 = (2000 * TICKS_PER_MS + 500) / 1000;
  localparam int CNT_W = $clog2(UT_R0 + 1);

  logic [FACTOR_W-1:0] factor_q;
  logic [FACTOR_W-1:0] units_left;
  logic [1:0]          rate_q;
  logic [CNT_W-1:0]    tick_cnt;
  logic [CNT_W-1:0]    unit_last;
  logic                busy_q;
  logic                settled_q;
  logic                unit_done;

  always_comb begin
    case (rate_q)
      2'd0:    unit_last = CNT_W'(UT_R0 - 1);
      2'd1:    unit_last = CNT_W'(UT_R1 - 1);
      2'd2:    unit_last = CNT_W'(UT_R2 - 1);
      default: unit_last = CNT_W'(UT_R3 - 1);
    endcase
  end

  assign unit_done = busy_q && tick && (tick_cnt == unit_last);
  assign busy      = busy_q;
  assign settled   = settled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      factor_q <= FACTOR_W'(FACTOR_RST);
    else if (factor_wr)
      factor_q <= factor_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q     <= '0;
      tick_cnt   <= '0;
      units_left <= '0;
      busy_q     <= 1'b0;
      settled_q  <= 1'b0;
    end else if (start) begin
      rate_q     <= rate_sel;
      tick_cnt   <= '0;
      units_left <= factor_q;
      busy_q     <= (factor_q != '0);
      settled_q  <= (factor_q == '0);
    end else begin
      settled_q <= 1'b0;
      if (unit_done) begin
        tick_cnt   <= '0;
        units_left <= units_left - 1'b1;
        if (units_left == FACTOR_W'(1)) begin
          busy_q    <= 1'b0;
          settled_q <= 1'b1;
        end
      end else if (busy_q && tick) begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> !settled);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(settled && busy));

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && factor_q != '0) |=> busy);

  p_zero_factor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && factor_q == '0) |=> (settled && !busy));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  p_unit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick_cnt <= unit_last));

endmodule

// File: tb/test_settle_timer.sv
`timescale 1ns/1ps
module test_settle_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       start = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       factor_wr = 1'b0;
  logic [3:0] factor_in = 4'd0;
  logic       busy;
  logic       settled;

  int checks = 0;
  int errors = 0;

  settle_timer i_settle_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .rate_sel(rate_sel),
    .factor_wr(factor_wr), .factor_in(factor_in), .busy(busy), .settled(settled)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_factor(input int v);
    @(negedge clk);
    factor_wr = 1'b1;
    factor_in = 4'(v);
    @(negedge clk);
    factor_wr = 1'b0;
  endtask

  // Starts a wait and drives ticks every 'period' cycles until 'want' ticks are sent.
  task automatic timed_run(input int rt, input int period, input int want, input bit disturb, input string req);
    int sent = 0;
    int cyc = 0;
    int early = 0;
    @(negedge clk);
    rate_sel = 2'(rt);
    start = 1'b1;
    tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (want == 0) begin
      chk(settled === 1'b1 && busy === 1'b0, req, "zero-factor pulse (settled)", int'(settled), 1);
      @(negedge clk);
      chk(settled === 1'b0, req, "zero-factor pulse ends", int'(settled), 0);
      return;
    end
    chk(busy === 1'b1 && settled === 1'b0, req, "busy after start", int'(busy), 1);
    while (sent < want) begin
      tick = (cyc % period) == 0;
      if (tick) sent++;
      if (disturb && cyc == 2) begin
        rate_sel = 2'(rt ^ 3);
        factor_wr = 1'b1;
        factor_in = 4'd1;
      end
      @(negedge clk);
      factor_wr = 1'b0;
      cyc++;
      if (sent < want && (settled !== 1'b0 || busy !== 1'b1)) early++;
    end
    tick = 1'b0;
    chk(early == 0, req, "no early completion (bad cycles)", early, 0);
    chk(settled === 1'b1 && busy === 1'b0, req, "settled after final tick", int'(settled), 1);
    @(negedge clk);
    chk(settled === 1'b0 && busy === 1'b0, req, "one-cycle pulse (R4)", int'(settled), 0);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(settled === 1'b0, "R1", "settled in reset", int'(settled), 0);
    timed_run(0, 1, 8 * 24, 1'b0, "R1");
  endtask

  task automatic t_rates;
    write_factor(15);
    timed_run(0, 1, 15 * 24, 1'b0, "R3");
    write_factor(5);
    timed_run(1, 3, 5 * 20, 1'b0, "R3");
    write_factor(15);
    timed_run(2, 2, 15 * 12, 1'b0, "R3");
    write_factor(1);
    timed_run(3, 1, 6, 1'b0, "R2");
  endtask

  task automatic t_zero;
    write_factor(0);
    timed_run(2, 1, 0, 1'b0, "R6");
  endtask

  task automatic t_idle;
    int seen = 0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (busy !== 1'b0 || settled !== 1'b0) seen++;
    end
    tick = 1'b0;
    chk(seen == 0, "R8", "idle ticks ignored (bad cycles)", seen, 0);
  endtask

  task automatic t_restart;
    write_factor(3);
    @(negedge clk);
    rate_sel = 2'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(busy === 1'b1, "R7", "still busy before restart", int'(busy), 1);
    write_factor(2);
    timed_run(2, 1, 2 * 12, 1'b0, "R7");
  endtask

  task automatic t_disturb;
    write_factor(4);
    timed_run(1, 2, 4 * 20, 1'b1, "R9");
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates();
    t_zero();
    t_idle();
    t_restart();
    t_disturb();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule